// File: doc/BRIEF.md
# Multicycle 32-bit RISC Core

This block is a small 32-bit processor core that spreads every instruction over several clock cycles. One memory port carries both instruction fetches and data transfers, and one ALU does every piece of arithmetic: the PC increment, the branch target, the effective address and the register-to-register result. Hidden holding registers keep each step's result for the step after it. These are the instruction word, the memory data word, the two source operands and the ALU result. A state machine sequences the steps.

The core runs register-register ALU operations, load word, store word, branch-if-equal and jump. Memory is addressed by word: the port carries bits [ADDR_W+1:2] of the byte address. Read data must be valid in the same cycle as the address, and a write is taken at the clock edge that ends a cycle with the write strobe high. A debug side exposes the PC, a pulse marking the fetch cycle of each instruction, and an asynchronous read port into the register file.

Top module: `mc_core`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, the PC and all registers are cleared and the core sits in its fetch step. After release, the first cycle is a fetch from word address 0 with `mem_rd` high, `mem_wr` low and `dbg_fetch` high.
- R2: Every instruction begins with a one-cycle fetch that reads the word at the PC and writes PC+4 into the PC. `dbg_fetch` is high exactly in that cycle.
- R3: An instruction with opcode bits [31:26] = 0x00 combines the registers named by bits [25:21] and [20:16] and writes the result to the register named by bits [15:11], taking 4 cycles. The function code in bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A set-if-less-than on signed values (result 1 or 0).
- R4: Opcode 0x23 loads the memory word at byte address reg[25:21] + sign-extended bits [15:0] into the register named by bits [20:16], taking 5 cycles. This holds when the destination is also the base register.
- R5: Opcode 0x2B writes the register named by bits [20:16] to memory at the same computed address, taking 4 cycles. `mem_wr` is high for exactly one cycle.
- R6: Opcode 0x04 compares the registers named by bits [25:21] and [20:16] and takes 3 cycles. If they are equal, the next PC is PC+4 + (sign-extended bits [15:0] shifted left by 2); otherwise it is PC+4.
- R7: Opcode 0x02 takes 3 cycles and sets the PC to {PC[31:28], bits [25:0], 2'b00}.
- R8: Register 0 reads as zero. Loads and ALU results aimed at it are discarded.
- R9: Any other opcode returns to fetch after 2 cycles. It changes no register, does not change the PC beyond the fetch increment, and writes no memory.
- R10: An opcode-0x00 word whose function code is not one of the five listed returns to fetch after 3 cycles and writes no register.
- R11: `mem_rd` and `mem_wr` are never high together. `mem_rd` is high only in fetch cycles and in the data-read cycle of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Word address for fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| dbg_fetch | output | 1 | High during the fetch cycle of each instruction |
| dbg_pc | output | 32 | Current PC |
| dbg_reg_sel | input | 5 | Register index for the debug read |
| dbg_reg_data | output | 32 | Contents of the selected register |

## Verification
Two functions share a single cycle in this core. The fetch cycle both reads the instruction and moves PC+4 through the ALU into the PC. The branch cycle uses the ALU to compare the operands while the PC is loaded from the target that was computed during decode. The bench provokes both by chaining a jump into branches with forward, zero and backward offsets, using equal and unequal operand pairs. It judges each case by the address of the next fetch and by the cycle count between fetch pulses. A load that overwrites its own base register is a related case: the address register is consumed and rewritten by the same instruction, so it is checked through the debug register read.

// File: rtl/mc_pkg.sv
package mc_pkg;

   localparam int unsigned XLEN   = 32;
   localparam int unsigned REG_AW = 5;

   localparam logic [5:0] OPC_ALU   = 6'h00;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] OPC_BEQ   = 6'h04;
   localparam logic [5:0] OPC_JMP   = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [3:0] {
      ST_FETCH, ST_DECODE, ST_ADDR, ST_EXEC, ST_RWB,
      ST_MRD, ST_MWR, ST_LWB, ST_BEQ, ST_JMP
   } mc_state_e;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
   } alu_op_e;

   typedef enum logic [0:0] { SRCX_PC, SRCX_REG } srcx_e;
   typedef enum logic [1:0] { SRCY_REG, SRCY_FOUR, SRCY_IMM, SRCY_BOFF } srcy_e;
   typedef enum logic [1:0] { PCS_ALU, PCS_HOLD, PCS_JUMP } pcsrc_e;

   typedef struct packed {
      logic    ir_we;
      logic    pc_we;
      pcsrc_e  pc_src;
      logic    mem_rd;
      logic    mem_wr;
      logic    data_addr;
      srcx_e   srcx;
      srcy_e   srcy;
      alu_op_e alu_op;
      logic    res_we;
      logic    opnd_we;
      logic    mdr_we;
      logic    reg_we;
      logic    wb_mem;
   } mc_ctl_t;

   function automatic logic opc_known(input logic [5:0] op);
      return (op == OPC_ALU) || (op == OPC_LOAD) || (op == OPC_STORE) ||
             (op == OPC_BEQ) || (op == OPC_JMP);
   endfunction

   function automatic logic fn_known(input logic [5:0] fn);
      return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
             (fn == FN_OR) || (fn == FN_SLT);
   endfunction

   function automatic alu_op_e fn_to_alu(input logic [5:0] fn);
      case (fn)
         FN_SUB:  return ALU_SUB;
         FN_AND:  return ALU_AND;
         FN_OR:   return ALU_OR;
         FN_SLT:  return ALU_SLT;
         default: return ALU_ADD;
      endcase
   endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [W-1:0]   res,
   output logic           zero
);

   if (W < 2) begin : g_bad_width
      $error("mc_alu: W must be at least 2");
   end

   logic lt_signed;
   assign lt_signed = $signed(x) < $signed(y);

   always_comb begin
      case (op)
         ALU_SUB: res = x - y;
         ALU_AND: res = x & y;
         ALU_OR:  res = x | y;
         ALU_SLT: res = {{(W-1){1'b0}}, lt_signed};
         default: res = x + y;
      endcase
   end

   assign zero = (res == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int unsigned W  = 32,
   parameter int unsigned AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] sel_a,
   input  logic [AW-1:0] sel_b,
   input  logic [AW-1:0] sel_d,
   output logic [W-1:0]  out_a,
   output logic [W-1:0]  out_b,
   output logic [W-1:0]  out_d,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_sel,
   input  logic [W-1:0]  wr_data
);

   localparam int unsigned NREG = 1 << AW;

   if (AW < 1 || AW > 6) begin : g_bad_aw
      $error("mc_regfile: AW out of range");
   end

   logic [W-1:0] cells [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_cell
      if (g == 0) begin : g_zero
         assign cells[g] = '0;
      end else begin : g_live
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_sel == AW'(g))
               q <= wr_data;
         end
         assign cells[g] = q;
      end
   end

   assign out_a = cells[sel_a];
   assign out_b = cells[sel_b];
   assign out_d = cells[sel_d];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   input  logic       alu_zero,
   output mc_state_e  state,
   output mc_ctl_t    ctl
);

   mc_state_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_FETCH;
      else
         state <= nxt;
   end

   always_comb begin
      nxt = ST_FETCH;
      case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (opcode)
               OPC_ALU:   nxt = ST_EXEC;
               OPC_LOAD:  nxt = ST_ADDR;
               OPC_STORE: nxt = ST_ADDR;
               OPC_BEQ:   nxt = ST_BEQ;
               OPC_JMP:   nxt = ST_JMP;
               default:   nxt = ST_FETCH;
            endcase
         end
         ST_EXEC:   nxt = fn_known(funct) ? ST_RWB : ST_FETCH;
         ST_ADDR:   nxt = (opcode == OPC_LOAD) ? ST_MRD : ST_MWR;
         ST_MRD:    nxt = ST_LWB;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_comb begin
      ctl        = '0;
      ctl.srcx   = SRCX_PC;
      ctl.srcy   = SRCY_REG;
      ctl.alu_op = ALU_ADD;
      ctl.pc_src = PCS_ALU;
      case (state)
         ST_FETCH: begin
            ctl.mem_rd = 1'b1;
            ctl.ir_we  = 1'b1;
            ctl.srcy   = SRCY_FOUR;
            ctl.pc_we  = 1'b1;
         end
         ST_DECODE: begin
            ctl.srcy    = SRCY_BOFF;
            ctl.res_we  = 1'b1;
            ctl.opnd_we = 1'b1;
         end
         ST_ADDR: begin
            ctl.srcx   = SRCX_REG;
            ctl.srcy   = SRCY_IMM;
            ctl.res_we = 1'b1;
         end
         ST_EXEC: begin
            ctl.srcx   = SRCX_REG;
            ctl.alu_op = fn_to_alu(funct);
            ctl.res_we = 1'b1;
         end
         ST_RWB: ctl.reg_we = 1'b1;
         ST_MRD: begin
            ctl.mem_rd    = 1'b1;
            ctl.data_addr = 1'b1;
            ctl.mdr_we    = 1'b1;
         end
         ST_MWR: begin
            ctl.mem_wr    = 1'b1;
            ctl.data_addr = 1'b1;
         end
         ST_LWB: begin
            ctl.reg_we = 1'b1;
            ctl.wb_mem = 1'b1;
         end
         ST_BEQ: begin
            ctl.srcx   = SRCX_REG;
            ctl.alu_op = ALU_SUB;
            ctl.pc_src = PCS_HOLD;
            ctl.pc_we  = alu_zero;
         end
         ST_JMP: begin
            ctl.pc_src = PCS_JUMP;
            ctl.pc_we  = 1'b1;
         end
         default: ;
      endcase
   end

   // R2
   fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FETCH |=> state == ST_DECODE);

   // R9
   bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE && !opc_known(opcode)) |=> state == ST_FETCH);

   // R10
   bad_funct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && !fn_known(funct)) |=> state == ST_FETCH);

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              dbg_fetch,
   output logic [31:0]       dbg_pc,
   input  logic [4:0]        dbg_reg_sel,
   output logic [31:0]       dbg_reg_data
);

   localparam int unsigned ADDR_HI = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_addr_w
      $error("mc_core: ADDR_W must lie in 2..30");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
      $error("mc_core: RESET_PC must be word aligned");
   end

   mc_state_e     state;
   mc_ctl_t       ctl;

   logic [XLEN-1:0] pc, ir, mdr, opnd_x, opnd_y, res_q;
   logic [XLEN-1:0] imm_sx, alu_x, alu_y, alu_res, pc_next, rf_a, rf_b;
   logic [XLEN-1:0] wb_data;
   logic [REG_AW-1:0] wb_sel;
   logic            alu_zero;

   assign imm_sx = {{16{ir[15]}}, ir[15:0]};

   mc_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .opcode   (ir[31:26]),
      .funct    (ir[5:0]),
      .alu_zero (alu_zero),
      .state    (state),
      .ctl      (ctl)
   );

   always_comb begin
      alu_x = (ctl.srcx == SRCX_REG) ? opnd_x : pc;
      case (ctl.srcy)
         SRCY_FOUR: alu_y = 32'd4;
         SRCY_IMM:  alu_y = imm_sx;
         SRCY_BOFF: alu_y = {imm_sx[29:0], 2'b00};
         default:   alu_y = opnd_y;
      endcase
   end

   mc_alu #(.W(XLEN)) u_alu (
      .op   (ctl.alu_op),
      .x    (alu_x),
      .y    (alu_y),
      .res  (alu_res),
      .zero (alu_zero)
   );

   always_comb begin
      case (ctl.pc_src)
         PCS_HOLD: pc_next = res_q;
         PCS_JUMP: pc_next = {pc[31:28], ir[25:0], 2'b00};
         default:  pc_next = alu_res;
      endcase
   end

   assign wb_sel  = ctl.wb_mem ? ir[20:16] : ir[15:11];
   assign wb_data = ctl.wb_mem ? mdr : res_q;

   mc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_a   (ir[25:21]),
      .sel_b   (ir[20:16]),
      .sel_d   (dbg_reg_sel),
      .out_a   (rf_a),
      .out_b   (rf_b),
      .out_d   (dbg_reg_data),
      .wr_en   (ctl.reg_we),
      .wr_sel  (wb_sel),
      .wr_data (wb_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc     <= RESET_PC;
         ir     <= '0;
         mdr    <= '0;
         opnd_x <= '0;
         opnd_y <= '0;
         res_q  <= '0;
      end else begin
         if (ctl.pc_we)   pc  <= pc_next;
         if (ctl.ir_we)   ir  <= mem_rdata;
         if (ctl.mdr_we)  mdr <= mem_rdata;
         if (ctl.opnd_we) begin
            opnd_x <= rf_a;
            opnd_y <= rf_b;
         end
         if (ctl.res_we)  res_q <= alu_res;
      end
   end

   assign mem_addr  = ctl.data_addr ? res_q[ADDR_HI:2] : pc[ADDR_HI:2];
   assign mem_wdata = opnd_y;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
   assign dbg_fetch = (state == ST_FETCH);
   assign dbg_pc    = pc;

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FETCH |=> pc == $past(pc) + 32'd4);

   // R7
   jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_JMP |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00});

   // R6
   beq_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BEQ && opnd_x != opnd_y) |=> $stable(pc));

   // R5
   store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   // R9
   bad_opcode_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE && !opc_known(ir[31:26])) |=> $stable(pc));

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

endmodule

// File: tb/test_mc_core.sv
module test_mc_core;

   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata, dbg_pc, dbg_reg_data;
   logic          mem_rd, mem_wr, dbg_fetch;
   logic [4:0]    dbg_reg_sel = '0;

   logic [31:0] mem [0:(1<<AW)-1];

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int durs [0:15];
   logic [31:0] pcs [0:15];
   int wrcnt, rdcnt, bothcnt;

   always #10 clk = ~clk;

   mc_core #(.ADDR_W(AW)) i_mc_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_rdata    (mem_rdata),
      .mem_rd       (mem_rd),
      .mem_wr       (mem_wr),
      .dbg_fetch    (dbg_fetch),
      .dbg_pc       (dbg_pc),
      .dbg_reg_sel  (dbg_reg_sel),
      .dbg_reg_data (dbg_reg_data)
   );

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
      return {6'h00, rs, rt, rd, 5'h00, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction
   function automatic logic [31:0] enc_j(input logic [25:0] tgt);
      return {6'h02, tgt};
   endfunction

   function automatic logic [31:0] model(input logic [5:0] fn, input logic [31:0] a, b);
      case (fn)
         6'h20: return a + b;
         6'h22: return a - b;
         6'h24: return a & b;
         6'h25: return a | b;
         default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rchk(input string tag, input logic [4:0] r, input logic [31:0] exp);
      dbg_reg_sel = r;
      #1;
      chk(tag, dbg_reg_data, exp);
   endtask

   task automatic boot();
      rst_n = 1'b0;
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(input int n);
      int idx = 0;
      int len = 0;
      wrcnt = 0; rdcnt = 0; bothcnt = 0;
      forever begin
         if (dbg_fetch) begin
            if (idx > 0) durs[idx-1] = len;
            pcs[idx] = dbg_pc;
            idx++;
            len = 0;
            if (idx > n) break;
         end
         if (mem_wr) wrcnt++;
         if (mem_rd) rdcnt++;
         if (mem_rd && mem_wr) bothcnt++;
         len++;
         if (len > 40) begin
            checks++;
            errors++;
            $display("FAIL R2 no fetch: actual=%0d cycles expected<=40", len);
            break;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      logic [31:0] vals [7];
      logic [5:0]  fns [5];
      int          offs [4];
      logic [31:0] exp;
      vals = '{32'h0, 32'h1, 32'h7, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
      fns  = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
      offs = '{2, 0, -3, 5};

      // R1: reset state
      boot();
      chk("R1 pc after reset", dbg_pc, 32'h0);
      chk("R1 fetch flag", 32'(dbg_fetch), 32'd1);
      chk("R1 read strobe", 32'(mem_rd), 32'd1);
      chk("R1 write strobe", 32'(mem_wr), 32'd0);
      chk("R1 address", 32'(mem_addr), 32'd0);
      rchk("R1 register cleared", 5'd5, 32'h0);

      // R3 R4 R5 R2 R11: sweep of operations over operand pairs
      for (int f = 0; f < 5; f++) begin
         for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
               boot();
               mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0200);
               mem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'h0204);
               mem[2] = enc_r(5'd1, 5'd2, 5'd3, fns[f]);
               mem[3] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0208);
               mem[32'h80] = vals[i];
               mem[32'h81] = vals[j];
               run(4);
               exp = model(fns[f], vals[i], vals[j]);
               rchk("R3 register result", 5'd3, exp);
               chk("R5 stored word", mem[32'h82], exp);
               if (f == 0 && i == 1 && j == 2) begin
                  chk("R4 load cycles", 32'(durs[0]), 32'd5);
                  chk("R3 alu cycles", 32'(durs[2]), 32'd4);
                  chk("R5 store cycles", 32'(durs[3]), 32'd4);
                  chk("R2 pc sequence", pcs[4], 32'h10);
                  chk("R2 pc second", pcs[1], 32'h4);
                  chk("R5 one write cycle", 32'(wrcnt), 32'd1);
                  chk("R11 read cycles", 32'(rdcnt), 32'd6);
                  chk("R11 exclusive strobes", 32'(bothcnt), 32'd0);
               end
            end
         end
      end

      // R4: negative offset and load into its own base register
      boot();
      mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0200);
      mem[1] = enc_i(6'h23, 5'd1, 5'd4, 16'hFFF8);
      mem[2] = enc_i(6'h23, 5'd1, 5'd1, 16'hFFFC);
      mem[32'h80] = 32'h0000_0210;
      mem[32'h82] = 32'hCAFE_F00D;
      mem[32'h83] = 32'h1234_ABCD;
      run(3);
      rchk("R4 negative offset load", 5'd4, 32'hCAFE_F00D);
      rchk("R4 base overwritten", 5'd1, 32'h1234_ABCD);
      chk("R4 load cycles", 32'(durs[2]), 32'd5);

      // R8: register 0 stays zero
      boot();
      mem[0] = enc_i(6'h23, 5'd0, 5'd0, 16'h0200);
      mem[1] = enc_i(6'h23, 5'd0, 5'd1, 16'h0200);
      mem[2] = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
      mem[3] = enc_i(6'h2B, 5'd0, 5'd0, 16'h020C);
      mem[32'h80] = 32'h0000_DEAD;
      mem[32'h83] = 32'hFFFF_FFFF;
      run(4);
      rchk("R8 r0 after writes", 5'd0, 32'h0);
      chk("R8 r0 stored as zero", mem[32'h83], 32'h0);
      rchk("R8 r1 loaded", 5'd1, 32'h0000_DEAD);

      // R6 R7: branch offsets, equal and unequal operands, reached by a jump
      for (int k = 0; k < 4; k++) begin
         for (int t = 0; t < 2; t++) begin
            boot();
            mem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0200);
            mem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0204);
            mem[2]  = enc_j(26'd16);
            mem[16] = enc_i(6'h04, 5'd1, 5'd2, 16'(offs[k]));
            mem[32'h80] = 32'd5;
            mem[32'h81] = (t == 0) ? 32'd5 : 32'd9;
            run(4);
            exp = (t == 0) ? 32'h44 + 32'(offs[k] * 4) : 32'h44;
            chk("R7 jump target", pcs[3], 32'h40);
            chk("R7 jump cycles", 32'(durs[2]), 32'd3);
            chk("R6 branch next pc", pcs[4], exp);
            chk("R6 branch cycles", 32'(durs[3]), 32'd3);
         end
      end

      // R7: far jump target
      boot();
      mem[0] = enc_j(26'h3F0);
      run(1);
      chk("R7 far jump", pcs[1], 32'h0000_0FC0);

      // R9 R10: unknown opcodes and function codes
      boot();
      mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0200);
      mem[1] = enc_i(6'h3F, 5'd1, 5'd2, 16'h0010);
      mem[2] = enc_i(6'h08, 5'd1, 5'd2, 16'h0001);
      mem[3] = enc_r(5'd1, 5'd1, 5'd6, 6'h3F);
      mem[4] = enc_r(5'd1, 5'd1, 5'd7, 6'h00);
      mem[32'h80] = 32'h55;
      run(5);
      chk("R9 unknown opcode cycles", 32'(durs[1]), 32'd2);
      chk("R9 second unknown opcode cycles", 32'(durs[2]), 32'd2);
      chk("R10 unknown funct cycles", 32'(durs[3]), 32'd3);
      chk("R10 unknown funct zero cycles", 32'(durs[4]), 32'd3);
      chk("R9 pc advances by 4 only", pcs[5], 32'h14);
      chk("R9 no memory write", 32'(wrcnt), 32'd0);
      rchk("R9 rt untouched", 5'd2, 32'h0);
      rchk("R10 rd untouched", 5'd6, 32'h0);
      rchk("R10 rd untouched again", 5'd7, 32'h0);
      rchk("R9 source intact", 5'd1, 32'h55);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule